// File: doc/BRIEF.md
# Phase-Stepped Clock Divider

This block takes a fast oversampling clock and builds three clocks from it. First comes a modelled oscillator clock at one eighth of the oversampling rate. Then comes an internal clock that divides that oscillator by a selectable factor. Last comes an off-chip clock at half the internal rate. A 3-bit phase select delays the oscillator clock in steps of one oversampling tick. One tick is one eighth of an oscillator period, or 45 degrees. Because the delay is applied before division, each step is the same absolute delay at every divide factor.

The divide factor is chosen by a 4-bit code. Only a few factors are legal, and the set has gaps. When the code is not legal, the block keeps its current factor and raises a flag. New codes are adopted only at the boundary just before a rising edge of the internal clock, so a divided cycle that has started always runs to the end. A phase change never shortens a high pulse: the block holds the oscillator low for extra ticks until the new phase lines up.

Top module: `phase_div_clkgen`

## Requirements
- R1: The divide code is the factor minus one. The legal codes are 0, 1, 2, 3, 4, 5, 7 and 15, which give the factors 1, 2, 3, 4, 5, 6, 8 and 16.
- R2: A phase select of p places every rising edge of `osc_clk` p oversampling ticks later than it falls with select 0, counted modulo 8. This holds at every divide factor, and every rising edge of `int_clk` coincides with a rising edge of `osc_clk`.
- R3: In steady state, `osc_clk` is high for 4 ticks and low for 4 ticks, whatever the divide factor.
- R4: In steady state, the period of `int_clk` is 8·N ticks for factor N.
- R5: For an even factor N, `int_clk` is high for 4·N ticks and low for 4·N ticks.
- R6: For factor 3, `int_clk` is high 8 and low 16 ticks. For factor 5, it is high 16 and low 24 ticks. Factor 1 gives the same waveform as `osc_clk`: high 4, low 4.
- R7: `ext_clk` toggles only on rising edges of `int_clk`, so it is high 8·N ticks and low 8·N ticks.
- R8: A new code takes effect only at the next rising edge of `int_clk`. The current divided cycle keeps its old high and low lengths. A phase increase of d steps stretches one low phase of `osc_clk` from 4 to 4+d ticks and never shortens a high phase.
- R9: While `div_code` holds an illegal code, `code_err` reads 1 one tick later and the active factor stays the same. `code_err` reads 0 one tick after a legal code is applied.
- R10: While `rst_n` is low, `osc_clk`, `int_clk`, `ext_clk` and `code_err` are all 0. After reset the active settings are factor 1 and phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_os | input | 1 | Oversampling clock, eight ticks per oscillator period |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| phase_sel | input | 3 | Phase step, 45 degrees (one tick) per unit |
| div_code | input | 4 | Divide factor minus one |
| osc_clk | output | 1 | Phase-shifted oscillator clock |
| int_clk | output | 1 | Divided internal clock |
| ext_clk | output | 1 | Off-chip clock, half the internal rate |
| code_err | output | 1 | Illegal divide code seen on the previous tick |

## Verification
On every cycle the embedded assertions check several local rules. Each oscillator high pulse lasts exactly four ticks, and a divided rising edge always coincides with an oscillator rising edge. The off-chip clock changes only on divided rising edges, and the sequencer's hold state keeps the oscillator low. The active code is always legal, and an illegal code presented at a boundary leaves the active factor unchanged. Only the bench scenarios can show the absolute measurements. These include the high and low tick counts for each of the eight factors and the phase offset of each select value relative to phase 0. They also include the stretched low phase after a phase change and the completion of an in-flight divided cycle after a code change.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned STEPS      = 8;
  localparam int unsigned STEP_W     = $clog2(STEPS);
  localparam int unsigned HIGH_STEPS = STEPS / 2;
  localparam int unsigned CODE_W     = 4;

  // divide code = factor - 1; only a sparse set of factors is accepted
  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    case (c)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd7, 4'd15: return 1'b1;
      default:                                          return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/psd_rst_sync.sv
module psd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sh_n = 1'b1;
    end else begin : g_chain
      always_comb sh_n = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/psd_cfg_gate.sv
module psd_cfg_gate
  import psd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic [STEP_W-1:0] ph_sel,
  input  logic              boundary,
  output logic [CODE_W-1:0] act_code_q,
  output logic [CODE_W-1:0] act_code_n,
  output logic [STEP_W-1:0] ph_delay,
  output logic              code_err
);
  logic [STEP_W-1:0] act_ph_q, act_ph_n;
  logic              err_q, err_n;
  logic              legal;

  always_comb begin
    legal      = code_ok(div_code);
    act_code_n = act_code_q;
    act_ph_n   = act_ph_q;
    if (boundary) begin
      act_ph_n = ph_sel;
      if (legal) act_code_n = div_code;
    end
    // extra ticks to hold the oscillator low so the new phase lines up
    ph_delay = ph_sel - act_ph_q;
    err_n    = !legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code_q <= '0;
      act_ph_q   <= '0;
      err_q      <= 1'b0;
    end else begin
      act_code_q <= act_code_n;
      act_ph_q   <= act_ph_n;
      err_q      <= err_n;
    end
  end

  assign code_err = err_q;

  assert_act_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok(act_code_q));

  assert_bad_code_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !code_ok(div_code)) |=> $stable(act_code_q));

  assert_change_at_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(act_code_q) && $stable(act_ph_q)));
endmodule

// File: rtl/psd_step_seq.sv
module psd_step_seq
  import psd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] act_code,
  input  logic [CODE_W-1:0] nxt_code,
  input  logic [STEP_W-1:0] ph_delay,
  output logic              boundary,
  output logic [STEP_W-1:0] pos_n,
  output logic [CODE_W-1:0] k_n
);
  logic [STEP_W-1:0] pos_q;
  logic [CODE_W-1:0] k_q;
  logic [STEP_W-1:0] stall_q, stall_n;

  // last tick of the last oscillator period of a divided cycle
  assign boundary = (stall_q == '0) && (pos_q == '0) && (k_q == act_code);

  always_comb begin
    pos_n   = pos_q;
    k_n     = k_q;
    stall_n = stall_q;
    if (stall_q != '0) begin
      stall_n = stall_q - STEP_W'(1);
      if (stall_q == STEP_W'(1)) begin
        pos_n = STEP_W'(1);
        k_n   = '0;
      end
    end else if (boundary) begin
      if (ph_delay == '0) begin
        pos_n = STEP_W'(1);
        k_n   = '0;
      end else begin
        pos_n   = '0;
        k_n     = nxt_code;   // parks the divider in its low half
        stall_n = ph_delay;
      end
    end else begin
      pos_n = pos_q + STEP_W'(1);
      if (pos_q == '0) k_n = k_q + CODE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      k_q     <= '0;
      stall_q <= '0;
    end else begin
      pos_q   <= pos_n;
      k_q     <= k_n;
      stall_q <= stall_n;
    end
  end

  assert_stall_holds_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q != '0) |-> (pos_q == '0));

  assert_period_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q == '0) |-> (k_q <= act_code));
endmodule

// File: rtl/psd_clk_shape.sv
module psd_clk_shape
  import psd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] pos_n,
  input  logic [CODE_W-1:0] k_n,
  input  logic [CODE_W-1:0] code_n,
  output logic              osc_clk,
  output logic              int_clk,
  output logic              ext_clk
);
  logic            osc_q, div_q, ext_q;
  logic            osc_d, div_d, ext_d;
  logic [CODE_W:0] nfac;
  logic [CODE_W:0] hi_periods;

  always_comb begin
    nfac       = {1'b0, code_n} + {{CODE_W{1'b0}}, 1'b1};
    hi_periods = nfac >> 1;   // N/2 for even, (N-1)/2 for odd
    osc_d      = (pos_n != '0) && (pos_n <= STEP_W'(HIGH_STEPS));
    if (code_n == '0) div_d = osc_d;
    else              div_d = ({1'b0, k_n} < hi_periods);
    ext_d = ext_q ^ (div_d & ~div_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q <= 1'b0;
      div_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      osc_q <= osc_d;
      div_q <= div_d;
      ext_q <= ext_d;
    end
  end

  assign osc_clk = osc_q;
  assign int_clk = div_q;
  assign ext_clk = ext_q;

  // run-length counters used only by the checks below
  logic [7:0] osc_run_q, div_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_run_q <= '0;
      div_run_q <= '0;
    end else begin
      osc_run_q <= osc_q ? osc_run_q + 8'd1 : 8'd0;
      div_run_q <= div_q ? div_run_q + 8'd1 : 8'd0;
    end
  end

  assert_osc_high_four_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_q) |-> (osc_run_q == 8'd4));

  assert_div_on_osc_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_q) |-> $rose(osc_q));

  assert_ext_on_div_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext_q) |-> $rose(div_q));

  assert_div_no_runt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_q) |-> (div_run_q >= 8'd4));
endmodule

// File: rtl/phase_div_clkgen.sv
module phase_div_clkgen
  import psd_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk_os,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] phase_sel,
  input  logic [CODE_W-1:0] div_code,
  output logic              osc_clk,
  output logic              int_clk,
  output logic              ext_clk,
  output logic              code_err
);
  logic              rst_s_n;
  logic              boundary;
  logic [CODE_W-1:0] act_code_q, act_code_n;
  logic [STEP_W-1:0] ph_delay;
  logic [STEP_W-1:0] pos_n;
  logic [CODE_W-1:0] k_n;

  psd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk_os),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s_n)
  );

  psd_cfg_gate u_cfg (
    .clk        (clk_os),
    .rst_n      (rst_s_n),
    .div_code   (div_code),
    .ph_sel     (phase_sel),
    .boundary   (boundary),
    .act_code_q (act_code_q),
    .act_code_n (act_code_n),
    .ph_delay   (ph_delay),
    .code_err   (code_err)
  );

  psd_step_seq u_seq (
    .clk      (clk_os),
    .rst_n    (rst_s_n),
    .act_code (act_code_q),
    .nxt_code (act_code_n),
    .ph_delay (ph_delay),
    .boundary (boundary),
    .pos_n    (pos_n),
    .k_n      (k_n)
  );

  psd_clk_shape u_shape (
    .clk     (clk_os),
    .rst_n   (rst_s_n),
    .pos_n   (pos_n),
    .k_n     (k_n),
    .code_n  (act_code_n),
    .osc_clk (osc_clk),
    .int_clk (int_clk),
    .ext_clk (ext_clk)
  );
endmodule

// File: tb/phase_div_clkgen_bench.sv
module phase_div_clkgen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] phase_sel;
  logic [3:0] div_code;
  logic       osc_clk, int_clk, ext_clk, code_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int r0     = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  phase_div_clkgen u_phase_div_clkgen (
    .clk_os    (clk),
    .rst_n     (rst_n),
    .phase_sel (phase_sel),
    .div_code  (div_code),
    .osc_clk   (osc_clk),
    .int_clk   (int_clk),
    .ext_clk   (ext_clk),
    .code_err  (code_err)
  );

  typedef struct {
    int    sel;
    int    hi;
    int    lo;
    string req;
  } item_t;

  item_t sb_q[$];
  event  go_ev, done_ev;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int s);
    case (s)
      0:       return osc_clk;
      1:       return int_clk;
      default: return ext_clk;
    endcase
  endfunction

  task automatic wait_rise(input int s);
    logic p;
    p = pick(s);
    @(negedge clk);
    while (!(pick(s) && !p)) begin
      p = pick(s);
      @(negedge clk);
    end
  endtask

  task automatic measure(input int s, output int hi, output int lo);
    wait_rise(s);
    hi = 1;
    @(negedge clk);
    while (pick(s)) begin hi++; @(negedge clk); end
    lo = 1;
    @(negedge clk);
    while (!pick(s)) begin lo++; @(negedge clk); end
  endtask

  // monitor: pops expected waveforms and compares them with measurements
  initial begin
    forever begin
      item_t it;
      int hi, lo;
      @(go_ev);
      it = sb_q.pop_front();
      measure(it.sel, hi, lo);
      check(hi == it.hi, {it.req, " high ticks"}, hi, it.hi);
      check(lo == it.lo, {it.req, " low ticks"}, lo, it.lo);
      ->done_ev;
    end
  end

  // driver side: queue an expectation and wait for the monitor
  task automatic expect_wave(input int s, input int hi, input int lo, input string req);
    item_t it;
    it.sel = s; it.hi = hi; it.lo = lo; it.req = req;
    sb_q.push_back(it);
    ->go_ev;
    @(done_ev);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_div(input int n);
    div_code = 4'(n - 1);   // R1: code = factor - 1
    settle(16 * n + 40);
  endtask

  task automatic check_phase(input int p, input string req);
    int d;
    wait_rise(0);
    d = (((cyc - r0) % 8) + 8) % 8;
    check(d == p, req, d, p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hi, lo;
    rst_n     = 1'b0;
    phase_sel = 3'd0;
    div_code  = 4'd0;
    settle(5);
    // R10: every output low while reset is held
    check({osc_clk, int_clk, ext_clk, code_err} == 4'b0, "R10 reset outputs",
          int'({osc_clk, int_clk, ext_clk, code_err}), 0);
    rst_n = 1'b1;
    wait_rise(0);
    r0 = cyc;
    // R10: default factor 1, so int_clk follows osc_clk
    expect_wave(1, 4, 4, "R10 default factor 1");

    // R4 R5 R6 R1: every legal factor
    set_div(1);  expect_wave(1, 4, 4, "R6 factor 1");
    set_div(2);  expect_wave(1, 8, 8, "R5 factor 2");
    set_div(3);  expect_wave(1, 8, 16, "R6 factor 3");
    set_div(4);  expect_wave(1, 16, 16, "R5 factor 4");
    set_div(5);  expect_wave(1, 16, 24, "R6 factor 5");
    set_div(6);  expect_wave(1, 24, 24, "R5 factor 6");
    set_div(8);  expect_wave(1, 32, 32, "R4 factor 8");
    set_div(16); expect_wave(1, 64, 64, "R4 R1 factor 16");
    expect_wave(0, 4, 4, "R3 oscillator at factor 16");

    // R7: off-chip clock at half the internal rate
    set_div(2); expect_wave(2, 16, 16, "R7 ext factor 2");
    set_div(3); expect_wave(2, 24, 24, "R7 ext factor 3");

    // R2: each phase step is one tick
    set_div(2);
    for (int p = 0; p < 8; p++) begin
      phase_sel = 3'(p);
      settle(60);
      check_phase(p, "R2 phase offset");
    end
    phase_sel = 3'd5;
    settle(60);
    expect_wave(0, 4, 4, "R3 oscillator at phase 5");
    set_div(16);
    phase_sel = 3'd3;
    settle(300);
    check_phase(3, "R2 phase at factor 16");

    // R9: illegal codes
    set_div(4);
    div_code = 4'd6;
    settle(2);
    check(code_err == 1'b1, "R9 flag for code 6", int'(code_err), 1);
    settle(100);
    expect_wave(1, 16, 16, "R9 factor held");
    div_code = 4'd9;
    settle(2);
    check(code_err == 1'b1, "R9 flag for code 9", int'(code_err), 1);
    div_code = 4'd3;
    settle(2);
    check(code_err == 1'b0, "R9 flag cleared", int'(code_err), 0);

    // R8: code change mid-cycle completes the old divided cycle
    set_div(16);
    wait_rise(1);
    hi = 1;
    repeat (10) begin @(negedge clk); if (int_clk) hi++; end
    div_code = 4'd1;
    @(negedge clk);
    while (int_clk) begin hi++; @(negedge clk); end
    lo = 1;
    @(negedge clk);
    while (!int_clk) begin lo++; @(negedge clk); end
    check(hi == 64, "R8 old high kept", hi, 64);
    check(lo == 64, "R8 old low kept", lo, 64);
    hi = 1;
    @(negedge clk);
    while (int_clk) begin hi++; @(negedge clk); end
    check(hi == 8, "R8 new factor after edge", hi, 8);

    // R8: phase increase stretches only the low phase
    set_div(1);
    phase_sel = 3'd0;
    settle(60);
    wait_rise(0);
    phase_sel = 3'd3;
    hi = 1;
    @(negedge clk);
    while (osc_clk) begin hi++; @(negedge clk); end
    lo = 1;
    @(negedge clk);
    while (!osc_clk) begin lo++; @(negedge clk); end
    check(hi == 4, "R8 high not shortened", hi, 4);
    check(lo == 7, "R8 low stretched by 3", lo, 7);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule